// File: doc/BRIEF.md
# Byte-Lane Select for a 16-bit Static RAM Board

This block decides when a static RAM board on a parallel backplane should respond to a bus cycle. It then picks which data buffers and which SRAM byte lanes take part. The memory is organised as two byte lanes. The even lane holds addresses with bit 0 low and the odd lane holds addresses with bit 0 high. A 16-bit master moves both lanes at once. An 8-bit master moves a single byte, which must be steered between the low half of the bus and whichever lane the address names.

The board answers only inside a window at the bottom of the address space. The window size is a parameter and defaults to 8 MB of a 24-bit space, so a second memory board decoded in the upper half never fights this one on a read. An asserted phantom line, taken from the alternative backplane pin 69, makes the board stay silent. While the address-strobe phase is active, every enable is held off.

The decoded bus strobes arrive already qualified by the bus interface. All outputs are active-low and registered: each one reflects the inputs seen at the previous rising clock edge, so every enable drops within one cycle after its strobe ends.

Top module: `sram_lane_sel`

## Requirements
- R1: An 8-bit read (rd8_n low) with address bit 0 low asserts cs_n and rd_even_n only. rd_even_n passes the even SRAM lane onto the low bus byte.
- R2: An 8-bit read with address bit 0 high asserts cs_n and rd_swap_n only. rd_swap_n passes the odd SRAM lane onto the low bus byte. rd_swap_n and rd_odd_n are never both asserted.
- R3: A 16-bit read (rd16_n low) asserts cs_n, rd_even_n and rd_odd_n, whatever the value of address bit 0. rd_odd_n passes the odd lane onto the high bus byte.
- R4: A 16-bit write (wr16_n low) asserts cs_n, wr_even_n, wr_odd_n, we_lo_n and we_hi_n, whatever the value of address bit 0.
- R5: An 8-bit write (wr8_n low) with address bit 0 low asserts cs_n, wr_even_n and we_lo_n. With address bit 0 high it asserts cs_n, wr_swap_n and we_hi_n, so the low bus byte is steered into the odd lane. No write enable is asserted without cs_n.
- R6: A cycle whose address is at or above 2**WIN_LOG2 (0x800000 by default) leaves every output high.
- R7: A cycle with phantom_n low leaves every output high.
- R8: A cycle with psync high leaves every output high.
- R9: A cycle with no strobe low, or with more than one of rd8_n, rd16_n, wr8_n and wr16_n low, leaves every output high. A read buffer and a write buffer are never asserted together.
- R10: Every output holds high during reset and changes only at a rising clock edge. It shows the decode of the inputs sampled at that edge, so an enable returns high in the cycle after its strobe ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Bus address |
| psync | input | 1 | Address-strobe phase, active high |
| phantom_n | input | 1 | Phantom line from pin 69, active low |
| rd8_n | input | 1 | 8-bit read strobe, active low |
| rd16_n | input | 1 | 16-bit read strobe, active low |
| wr8_n | input | 1 | 8-bit write strobe, active low |
| wr16_n | input | 1 | 16-bit write strobe, active low |
| cs_n | output | 1 | SRAM chip select |
| we_lo_n | output | 1 | Even-lane SRAM write enable |
| we_hi_n | output | 1 | Odd-lane SRAM write enable |
| rd_even_n | output | 1 | Even lane to low bus byte |
| rd_odd_n | output | 1 | Odd lane to high bus byte |
| rd_swap_n | output | 1 | Odd lane to low bus byte |
| wr_even_n | output | 1 | Low bus byte to even lane |
| wr_odd_n | output | 1 | High bus byte to odd lane |
| wr_swap_n | output | 1 | Low bus byte to odd lane |

## Verification
On every cycle, the assertions check the suppression rules. The window, phantom, pSYNC and strobe-count conditions must each leave all enables high one cycle later. Read and write buffers must never be enabled together. The two odd-lane read paths must never be enabled together, and no write enable may appear without chip select. The choice of which lane responds to each strobe and address bit 0 is shown only by the bench sweep. The same holds for independence from bit 0 on 16-bit transfers and for the exact edge at which outputs change. That sweep covers every strobe combination, both phantom and pSYNC levels, and addresses on both sides of the window boundary.

// File: rtl/sram_lane_sel.sv
module sram_lane_sel #(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              psync,
  input  logic              phantom_n,
  input  logic              rd8_n,
  input  logic              rd16_n,
  input  logic              wr8_n,
  input  logic              wr16_n,
  output logic              cs_n,
  output logic              we_lo_n,
  output logic              we_hi_n,
  output logic              rd_even_n,
  output logic              rd_odd_n,
  output logic              rd_swap_n,
  output logic              wr_even_n,
  output logic              wr_odd_n,
  output logic              wr_swap_n
);

  localparam int TOP_W = ADDR_W - WIN_LOG2;

  logic [3:0] strb;
  logic       one_strb;
  logic       in_win;
  logic       sel;
  logic       a0;
  logic [8:0] nxt;
  logic [8:0] q;

  assign strb     = {~rd8_n, ~rd16_n, ~wr8_n, ~wr16_n};
  assign one_strb = (strb != 4'b0) && ((strb & (strb - 4'd1)) == 4'b0);
  assign in_win   = (addr[ADDR_W-1:WIN_LOG2] == {TOP_W{1'b0}});
  assign sel      = in_win && phantom_n && !psync && one_strb;
  assign a0       = addr[0];

  always_comb begin
    nxt = '1;
    if (sel) begin
      nxt[8] = 1'b0;
      unique case (strb)
        4'b1000: if (a0) nxt[3] = 1'b0; else nxt[5] = 1'b0;
        4'b0100: begin nxt[5] = 1'b0; nxt[4] = 1'b0; end
        4'b0010: if (a0) begin nxt[0] = 1'b0; nxt[6] = 1'b0; end
                 else    begin nxt[2] = 1'b0; nxt[7] = 1'b0; end
        default: begin nxt[2] = 1'b0; nxt[1] = 1'b0; nxt[7] = 1'b0; nxt[6] = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '1;
    else        q <= nxt;

  assign {cs_n, we_lo_n, we_hi_n, rd_even_n, rd_odd_n, rd_swap_n,
          wr_even_n, wr_odd_n, wr_swap_n} = q;

  // R6
  upper_window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:WIN_LOG2] != {TOP_W{1'b0}}) |=> (&q));

  // R7
  phantom_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phantom_n |=> (&q));

  // R8
  psync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psync |=> (&q));

  // R9
  strobe_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({rd8_n, rd16_n, wr8_n, wr16_n}) != 3) |=> (&q));

  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({rd_even_n, rd_odd_n, rd_swap_n}) == 3) ||
    ($countones({wr_even_n, wr_odd_n, wr_swap_n}) == 3));

  // R2
  odd_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_swap_n && !rd_odd_n));

  // R5
  we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_lo_n || !we_hi_n) |-> !cs_n);

endmodule

// File: tb/sram_lane_sel_tb_top.sv
module sram_lane_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        psync = 1'b0;
  logic        phantom_n = 1'b1;
  logic        rd8_n = 1'b1, rd16_n = 1'b1, wr8_n = 1'b1, wr16_n = 1'b1;
  logic        cs_n, we_lo_n, we_hi_n, rd_even_n, rd_odd_n, rd_swap_n;
  logic        wr_even_n, wr_odd_n, wr_swap_n;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sram_lane_sel dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .psync(psync), .phantom_n(phantom_n),
    .rd8_n(rd8_n), .rd16_n(rd16_n), .wr8_n(wr8_n), .wr16_n(wr16_n),
    .cs_n(cs_n), .we_lo_n(we_lo_n), .we_hi_n(we_hi_n),
    .rd_even_n(rd_even_n), .rd_odd_n(rd_odd_n), .rd_swap_n(rd_swap_n),
    .wr_even_n(wr_even_n), .wr_odd_n(wr_odd_n), .wr_swap_n(wr_swap_n));

  function automatic logic [8:0] outs();
    return {cs_n, we_lo_n, we_hi_n, rd_even_n, rd_odd_n, rd_swap_n,
            wr_even_n, wr_odd_n, wr_swap_n};
  endfunction

  // bit order: cs, we_lo, we_hi, rd_even, rd_odd, rd_swap, wr_even, wr_odd, wr_swap
  function automatic logic [8:0] model(logic [23:0] a, logic ps, logic ph_n, logic [3:0] s_n);
    logic [8:0] e = '1;
    int act = 0;
    for (int i = 0; i < 4; i++) if (!s_n[i]) act++;
    if (!ps && ph_n && (a < (24'd1 << 23)) && act == 1) begin
      e[8] = 1'b0;
      if (!s_n[3])      begin if (a[0]) e[3] = 1'b0; else e[5] = 1'b0; end
      else if (!s_n[2]) begin e[5] = 1'b0; e[4] = 1'b0; end
      else if (!s_n[1]) begin if (a[0]) begin e[0] = 1'b0; e[6] = 1'b0; end
                              else begin e[2] = 1'b0; e[7] = 1'b0; end end
      else              begin e[2] = 1'b0; e[1] = 1'b0; e[7] = 1'b0; e[6] = 1'b0; end
    end
    return e;
  endfunction

  function automatic string tag(logic [23:0] a, logic ps, logic ph_n, logic [3:0] s_n);
    int act = 0;
    for (int i = 0; i < 4; i++) if (!s_n[i]) act++;
    if (ps) return "R8";
    if (!ph_n) return "R7";
    if (a >= (24'd1 << 23)) return "R6";
    if (act != 1) return "R9";
    if (!s_n[3]) return a[0] ? "R2" : "R1";
    if (!s_n[2]) return "R3";
    if (!s_n[1]) return "R5";
    return "R4";
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b (addr %h psync %b phantom_n %b strobes %b)",
               req, act, exp, addr, psync, phantom_n, {rd8_n, rd16_n, wr8_n, wr16_n});
    end
  endtask

  task automatic drive(logic [23:0] a, logic ps, logic ph_n, logic [3:0] s_n);
    @(negedge clk);
    addr = a; psync = ps; phantom_n = ph_n;
    {rd8_n, rd16_n, wr8_n, wr16_n} = s_n;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    logic [23:0] bases [6] = '{24'h000000, 24'h3A5C10, 24'h7FFFFE,
                               24'h800000, 24'hC00000, 24'hFFFFFE};
    logic [8:0] held;
    // R10: reset holds all outputs high even with a valid strobe present
    drive(24'h000010, 1'b0, 1'b1, 4'b0111);
    @(negedge clk);
    check("R10", outs(), 9'h1FF);
    rst_n = 1'b1;
    drive(24'h000000, 1'b0, 1'b1, 4'b1111);
    @(negedge clk);
    check("R10", outs(), 9'h1FF);

    for (int b = 0; b < 6; b++)
      for (int lsb = 0; lsb < 2; lsb++)
        for (int s = 0; s < 16; s++)
          for (int ps = 0; ps < 2; ps++)
            for (int ph = 0; ph < 2; ph++) begin
              logic [23:0] a = bases[b] | 24'(lsb);
              drive(a, ps[0], ph[0], s[3:0]);
              @(negedge clk);
              check(tag(a, ps[0], ph[0], s[3:0]), outs(),
                    model(a, ps[0], ph[0], s[3:0]));
            end

    // R10: no change before the edge, change after it, release in next cycle
    drive(24'h000101, 1'b0, 1'b1, 4'b1101);
    @(negedge clk);
    held = outs();
    check("R5", held, 9'b0_1_0_111_110);
    drive(24'h000100, 1'b0, 1'b1, 4'b1011);
    #1 check("R10", outs(), held);
    @(negedge clk);
    check("R3", outs(), 9'b0_1_1_001_111);
    drive(24'h000100, 1'b0, 1'b1, 4'b1111);
    @(negedge clk);
    check("R10", outs(), 9'h1FF);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10: watchdog expired, actual hung expected finished");
      finish_run();
    end
  end
endmodule